// File: doc/BRIEF.md
# Packet Buffer Data Port with Prefetch

This block gives a host a narrow window onto a byte-addressed packet buffer RAM. The host first loads a pointer word, which holds a buffer offset, an area select bit and two control bits. It then reads or writes a 16-bit data port. Behind the port, a small prefetch queue is kept full from RAM for reads. For writes, a staging queue collects host bytes and hands them to RAM in byte or word cycles. With auto-increment on, the host sees the buffer as one contiguous stream, whatever the alignment of the pointer.

Each RAM cycle moves either one byte or one word. A word always sits at an even address. An odd start therefore splits into a byte cycle followed by word cycles. When the port cannot yet satisfy a host access, a not-ready output asks the host to hold that access until the queue catches up.

Top module: `pkt_port`

## Requirements
- R1: A pointer load takes the offset from `ptr_wdata_i[10:0]`, the area select from bit 15, auto-increment from bit 14 and read direction from bit 13. RAM addresses are `{area, offset}`. A pointer load empties the prefetch queue, and fetching restarts at the new offset, so the next read returns bytes from the new location.
- R2: After a read-direction pointer load at an odd offset p, the first RAM cycle is a byte read of p and the next is a word read of p+1, which leaves three bytes queued.
- R3: The prefetch queue never holds more than its depth. A fetch is only requested when the queue has room for its full width, so with a depth of 4 and an odd start, no third fetch is issued until the host consumes data.
- R4: A word read (`dat_be_i` = 11) returns the byte at the pointer on bits [7:0] and the next byte on bits [15:8], at any alignment. With auto-increment on, successive accesses return successive buffer bytes.
- R5: A byte read with `dat_be_i` = 01 returns the byte on bits [7:0]; with 10 it returns the byte on bits [15:8]. The other lane reads zero. A byte access advances the pointer by one and a word access by two.
- R6: `not_ready_o` is high while a data read finds fewer queued bytes than the access needs, or while a data write finds too little room. Such an access takes no effect until it is repeated with `not_ready_o` low.
- R7: With auto-increment off, repeated reads return the same location again and the pointer does not move.
- R8: Writes with auto-increment on land in consecutive buffer bytes starting at the pointer, at any alignment. A byte write with `dat_be_i` = 01 writes bits [7:0], and with 10 it writes bits [15:8].
- R9: A RAM write cycle starts when the write queue holds more than two bytes, even while the host keeps writing. A cycle also starts when the queue is not empty and no host write is accepted in that cycle.
- R10: With auto-increment off, every write lands at the pointer offset. A later write overwrites the earlier bytes.
- R11: A pointer load while write bytes are still queued raises `not_ready_o` and is held off until the queue has drained.
- R12: Each granted RAM cycle moves one byte, carried on bits [7:0], or one word at an even address, with the lower address on bits [7:0]. Read data is taken in the cycle the grant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_we_i | input | 1 | Pointer load strobe |
| ptr_wdata_i | input | 16 | Pointer word: offset, area, auto-increment, direction |
| dat_rd_i | input | 1 | Data port read request |
| dat_wr_i | input | 1 | Data port write request |
| dat_be_i | input | 2 | Byte lanes of the data access |
| dat_wdata_i | input | 16 | Host write data |
| dat_rdata_o | output | 16 | Host read data, valid while the read is accepted |
| not_ready_o | output | 1 | Host access must be held |
| ram_req_o | output | 1 | RAM cycle request |
| ram_gnt_i | input | 1 | RAM cycle grant |
| ram_we_o | output | 1 | RAM cycle is a write |
| ram_word_o | output | 1 | RAM cycle moves a word (else a byte) |
| ram_addr_o | output | 12 | RAM byte address including area bit |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data |

## Verification
Some properties are checked on every cycle. Neither queue may overflow or underflow. Word RAM cycles must use even addresses. A read load at an odd offset must be followed by a byte fetch of that offset. A write queue holding three or more bytes must be requesting RAM. Whether the data stream stays contiguous across mixed byte and word accesses can only be shown by the bench. The same goes for lane placement, repeat reads without auto-increment, flushing on reload, and the stall-then-complete sequences under a withheld or random grant. The bench compares the port's data and the RAM contents against its own buffer model.

// File: rtl/pkt_port_pkg.sv
`timescale 1ns/1ps
package pkt_port_pkg;
  localparam int unsigned PTR_RCV_BIT  = 15;
  localparam int unsigned PTR_AINC_BIT = 14;
  localparam int unsigned PTR_RD_BIT   = 13;

  typedef struct packed {
    logic rcv;
    logic ainc;
    logic rdir;
  } ptr_flags_t;

  function automatic logic [1:0] lane_count(input logic [1:0] be);
    return {1'b0, be[0]} + {1'b0, be[1]};
  endfunction
endpackage

// File: rtl/pkt_port_bfifo.sv
`timescale 1ns/1ps
// Byte queue: up to two bytes in and two bytes out per cycle, head in bits [15:0].
module pkt_port_bfifo #(
  parameter int unsigned DEPTH = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic [1:0]                     push_n_i,
  input  logic [15:0]                    push_d_i,
  input  logic [1:0]                     pop_n_i,
  output logic [$clog2(DEPTH+1)-1:0]     cnt_o,
  output logic [15:0]                    head_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned BW = DEPTH * 8;

  logic [BW-1:0] q_q, q_d, push_w;
  logic [CW-1:0] cnt_q, base;
  logic [15:0]   push_m;

  always_comb begin
    base   = cnt_q - CW'(pop_n_i);
    push_m = (push_n_i == 2'd2) ? push_d_i :
             (push_n_i == 2'd1) ? {8'h00, push_d_i[7:0]} : 16'h0000;
    push_w = BW'(push_m);
    q_d    = (q_q >> {pop_n_i, 3'b000}) | (push_w << {base, 3'b000});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      q_q   <= '0;
      cnt_q <= '0;
    end else begin
      q_q   <= q_d;
      cnt_q <= base + CW'(push_n_i);
    end
  end

  assign cnt_o  = cnt_q;
  assign head_o = q_q[15:0];

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (({1'b0, cnt_q} - (CW+1)'(pop_n_i) + (CW+1)'(push_n_i)) <= (CW+1)'(DEPTH)));
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (CW'(pop_n_i) <= cnt_q));
endmodule

// File: rtl/pkt_port_ptr.sv
`timescale 1ns/1ps
module pkt_port_ptr
  import pkt_port_pkg::*;
#(
  parameter int unsigned OFF_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [15:0]      load_data_i,
  input  logic             adv_i,
  input  logic [1:0]       adv_n_i,
  output logic [OFF_W-1:0] off_o,
  output ptr_flags_t       flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_o   <= '0;
      flags_o <= '0;
    end else if (load_i) begin
      off_o        <= load_data_i[OFF_W-1:0];
      flags_o.rcv  <= load_data_i[PTR_RCV_BIT];
      flags_o.ainc <= load_data_i[PTR_AINC_BIT];
      flags_o.rdir <= load_data_i[PTR_RD_BIT];
    end else if (adv_i) begin
      off_o <= off_o + OFF_W'(adv_n_i);
    end
  end
endmodule

// File: rtl/pkt_port.sv
`timescale 1ns/1ps
module pkt_port
  import pkt_port_pkg::*;
#(
  parameter int unsigned OFF_W    = 11,
  parameter int unsigned RQ_DEPTH = 4,
  parameter int unsigned WQ_DEPTH = 4,
  localparam int unsigned AW      = OFF_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_we_i,
  input  logic [15:0]   ptr_wdata_i,
  input  logic          dat_rd_i,
  input  logic          dat_wr_i,
  input  logic [1:0]    dat_be_i,
  input  logic [15:0]   dat_wdata_i,
  output logic [15:0]   dat_rdata_o,
  output logic          not_ready_o,
  output logic          ram_req_o,
  input  logic          ram_gnt_i,
  output logic          ram_we_o,
  output logic          ram_word_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [15:0]   ram_wdata_o,
  input  logic [15:0]   ram_rdata_i
);
  localparam int unsigned RCW = $clog2(RQ_DEPTH + 1);
  localparam int unsigned WCW = $clog2(WQ_DEPTH + 1);

  logic [OFF_W-1:0] ptr_off, fetch_q, wr_addr_q;
  ptr_flags_t       fl;
  logic [RCW-1:0]   rq_cnt, rq_space;
  logic [WCW-1:0]   wq_cnt, wq_space;
  logic [15:0]      rq_head, wq_head, wq_push_d;
  logic [1:0]       need, rq_push_n, rq_pop_n, wq_push_n, wq_pop_n;
  logic ptr_load, ptr_stall, rd_acc, rd_stall, rd_pop, wr_acc, wr_stall, wr_push;
  logic rq_flush, f_word, f_byte, fetch_req, fetch_go, d_word, drain_req, drain_go;

  always_comb begin
    need      = lane_count(dat_be_i);
    ptr_stall = ptr_we_i && (wq_cnt != '0);
    ptr_load  = ptr_we_i && (wq_cnt == '0);
    // read side
    rd_acc    = dat_rd_i && !ptr_we_i && fl.rdir && (need != 2'd0);
    rd_stall  = rd_acc && (rq_cnt < RCW'(need));
    rd_pop    = rd_acc && !rd_stall;
    rq_flush  = ptr_load || (rd_pop && !fl.ainc);
    rq_space  = RCW'(RQ_DEPTH) - rq_cnt;
    f_word    = !fetch_q[0] && (rq_space >= RCW'(2));
    f_byte    = fetch_q[0] && (rq_space >= RCW'(1));
    fetch_req = fl.rdir && !rq_flush && (f_word || f_byte);
    fetch_go  = fetch_req && ram_gnt_i;
    rq_push_n = fetch_go ? (f_word ? 2'd2 : 2'd1) : 2'd0;
    rq_pop_n  = rd_pop ? need : 2'd0;
    // write side
    wq_space  = WCW'(WQ_DEPTH) - wq_cnt;
    wr_acc    = dat_wr_i && !ptr_we_i && !fl.rdir && (need != 2'd0);
    wr_stall  = wr_acc && (fl.ainc ? (wq_space < WCW'(need)) : (wq_cnt != '0));
    wr_push   = wr_acc && !wr_stall;
    wq_push_n = wr_push ? need : 2'd0;
    unique case (dat_be_i)
      2'b10:   wq_push_d = {8'h00, dat_wdata_i[15:8]};
      2'b01:   wq_push_d = {8'h00, dat_wdata_i[7:0]};
      default: wq_push_d = dat_wdata_i;
    endcase
    d_word    = !wr_addr_q[0] && (wq_cnt >= WCW'(2));
    drain_req = !fl.rdir && (wq_cnt != '0) && ((wq_cnt >= WCW'(3)) || !wr_push);
    drain_go  = drain_req && ram_gnt_i;
    wq_pop_n  = drain_go ? (d_word ? 2'd2 : 2'd1) : 2'd0;
    // host read data lanes
    unique case (dat_be_i)
      2'b11:   dat_rdata_o = rq_head;
      2'b01:   dat_rdata_o = {8'h00, rq_head[7:0]};
      2'b10:   dat_rdata_o = {rq_head[7:0], 8'h00};
      default: dat_rdata_o = 16'h0000;
    endcase
  end

  assign not_ready_o = ptr_stall || rd_stall || wr_stall;
  assign ram_req_o   = fetch_req || drain_req;
  assign ram_we_o    = !fl.rdir;
  assign ram_word_o  = fl.rdir ? f_word : d_word;
  assign ram_addr_o  = {fl.rcv, fl.rdir ? fetch_q : wr_addr_q};
  assign ram_wdata_o = d_word ? wq_head : {8'h00, wq_head[7:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q   <= '0;
      wr_addr_q <= '0;
    end else begin
      if (ptr_load)                  fetch_q <= ptr_wdata_i[OFF_W-1:0];
      else if (rd_pop && !fl.ainc)   fetch_q <= ptr_off;
      else if (fetch_go)             fetch_q <= fetch_q + OFF_W'(rq_push_n);
      if (ptr_load)                  wr_addr_q <= ptr_wdata_i[OFF_W-1:0];
      else if (wr_push && !fl.ainc)  wr_addr_q <= ptr_off;
      else if (drain_go)             wr_addr_q <= wr_addr_q + OFF_W'(wq_pop_n);
    end
  end

  pkt_port_ptr #(.OFF_W(OFF_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ptr_load), .load_data_i(ptr_wdata_i),
    .adv_i((rd_pop || wr_push) && fl.ainc), .adv_n_i(need),
    .off_o(ptr_off), .flags_o(fl)
  );

  pkt_port_bfifo #(.DEPTH(RQ_DEPTH)) u_rq (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(rq_flush),
    .push_n_i(rq_push_n), .push_d_i(f_word ? ram_rdata_i : {8'h00, ram_rdata_i[7:0]}),
    .pop_n_i(rq_pop_n), .cnt_o(rq_cnt), .head_o(rq_head)
  );

  pkt_port_bfifo #(.DEPTH(WQ_DEPTH)) u_wq (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(1'b0),
    .push_n_i(wq_push_n), .push_d_i(wq_push_d),
    .pop_n_i(wq_pop_n), .cnt_o(wq_cnt), .head_o(wq_head)
  );

  p_word_even_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_req_o && ram_word_o |-> !ram_addr_o[0]);
  p_odd_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i && !not_ready_o && ptr_wdata_i[PTR_RD_BIT] && ptr_wdata_i[0]
    |=> ptr_we_i || (ram_req_o && !ram_word_o &&
        ram_addr_o == $past({ptr_wdata_i[PTR_RCV_BIT], ptr_wdata_i[OFF_W-1:0]})));
  p_drain_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl.rdir && (wq_cnt >= WCW'(3)) |-> ram_req_o && ram_we_o);
  p_stall_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_ready_o |-> dat_rd_i || dat_wr_i || ptr_we_i);
endmodule

// File: tb/pkt_port_bench.sv
`timescale 1ns/1ps
module pkt_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ptr_we = 1'b0, dat_rd = 1'b0, dat_wr = 1'b0;
  logic [15:0] ptr_wdata = '0, dat_wdata = '0;
  logic [1:0]  dat_be = 2'b00;
  logic [15:0] dat_rdata, ram_wdata, ram_rdata;
  logic not_ready, ram_req, ram_we, ram_word;
  logic ram_gnt = 1'b0;
  logic [11:0] ram_addr;
  logic rand_gnt = 1'b0, force_gnt = 1'b1;

  logic [7:0]  mem  [0:4095];
  logic [7:0]  expm [0:4095];
  logic [11:0] acc_addr [0:15];
  logic        acc_word [0:15];
  int acc_cnt = 0, odd_word = 0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pkt_port u_pkt_port (
    .clk_i(clk), .rst_ni(rst_n), .ptr_we_i(ptr_we), .ptr_wdata_i(ptr_wdata),
    .dat_rd_i(dat_rd), .dat_wr_i(dat_wr), .dat_be_i(dat_be), .dat_wdata_i(dat_wdata),
    .dat_rdata_o(dat_rdata), .not_ready_o(not_ready),
    .ram_req_o(ram_req), .ram_gnt_i(ram_gnt), .ram_we_o(ram_we), .ram_word_o(ram_word),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  assign ram_rdata = ram_word ? {mem[{ram_addr[11:1], 1'b1}], mem[ram_addr]} : {8'h00, mem[ram_addr]};

  always @(negedge clk) ram_gnt <= rand_gnt ? (($urandom % 4) != 0) : force_gnt;

  always @(posedge clk) begin
    if (ram_req && ram_gnt) begin
      acc_addr[acc_cnt[3:0]] = ram_addr;
      acc_word[acc_cnt[3:0]] = ram_word;
      acc_cnt = acc_cnt + 1;
      if (ram_word && ram_addr[0]) odd_word = odd_word + 1;
      if (ram_we) begin
        mem[ram_addr] <= ram_wdata[7:0];
        if (ram_word) mem[{ram_addr[11:1], 1'b1}] <= ram_wdata[15:8];
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  function automatic logic [11:0] ix(input logic rcv, input logic [10:0] off);
    return {rcv, off};
  endfunction

  function automatic logic [15:0] exp_rd(input logic rcv, input logic [10:0] off, input logic [1:0] be);
    logic [7:0] lo, hi;
    lo = expm[ix(rcv, off)];
    hi = expm[ix(rcv, off + 11'd1)];
    if (be == 2'b11) return {hi, lo};
    if (be == 2'b01) return {8'h00, lo};
    return {lo, 8'h00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exv);
    checks++;
    if (act !== exv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exv);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_ptr(input logic rcv, input logic ainc, input logic rd, input logic [10:0] off);
    @(negedge clk);
    ptr_we = 1'b1;
    ptr_wdata = {rcv, ainc, rd, 2'b00, off};
    #1;
    while (not_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ptr_we = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] be, output logic [15:0] d);
    @(negedge clk);
    dat_rd = 1'b1; dat_be = be;
    #1;
    while (not_ready) begin @(negedge clk); #1; end
    d = dat_rdata;
    @(posedge clk); #1;
    dat_rd = 1'b0;
  endtask

  task automatic host_wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    dat_wr = 1'b1; dat_be = be; dat_wdata = d;
    #1;
    while (not_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    dat_wr = 1'b0;
  endtask

  initial begin
    logic [15:0] d;
    logic [10:0] off;
    logic [1:0]  be;
    logic        rcv;
    int          base;
    logic [11:0] wl [0:15];
    int          wn;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) begin
      mem[i]  = 8'((i * 37 + 11) ^ (i >> 5));
      expm[i] = 8'((i * 37 + 11) ^ (i >> 5));
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset not_ready", {31'd0, not_ready}, 32'd0);
    chk("R1 reset ram_req", {31'd0, ram_req}, 32'd0);

    // R2/R3: odd start fetches byte then word, then stops with three queued
    force_gnt = 1'b1;
    base = acc_cnt;
    load_ptr(1'b0, 1'b1, 1'b1, 11'h105);
    cycles(6);
    chk("R3 fetch count", 32'(acc_cnt - base), 32'd2);
    chk("R2 first addr", {20'd0, acc_addr[4'(base)]}, 32'h105);
    chk("R2 first is byte", {31'd0, acc_word[4'(base)]}, 32'd0);
    chk("R2 second addr", {20'd0, acc_addr[4'(base + 1)]}, 32'h106);
    chk("R2 second is word", {31'd0, acc_word[4'(base + 1)]}, 32'd1);
    host_rd(2'b11, d);
    chk("R4 odd word read", {16'd0, d}, {16'd0, exp_rd(1'b0, 11'h105, 2'b11)});

    // R6: read before data is queued
    force_gnt = 1'b0;
    cycles(2);
    load_ptr(1'b0, 1'b1, 1'b1, 11'h020);
    @(negedge clk);
    dat_rd = 1'b1; dat_be = 2'b11;
    #1;
    chk("R6 stall while empty", {31'd0, not_ready}, 32'd1);
    @(negedge clk); #1;
    chk("R6 stall held", {31'd0, not_ready}, 32'd1);
    force_gnt = 1'b1;
    while (not_ready) begin @(negedge clk); #1; end
    chk("R6 data after stall", {16'd0, dat_rdata}, {16'd0, exp_rd(1'b0, 11'h020, 2'b11)});
    @(posedge clk); #1;
    dat_rd = 1'b0;

    // R7: no auto-increment repeats the location
    load_ptr(1'b0, 1'b0, 1'b1, 11'h033);
    host_rd(2'b11, d);
    chk("R7 first read", {16'd0, d}, {16'd0, exp_rd(1'b0, 11'h033, 2'b11)});
    host_rd(2'b11, d);
    chk("R7 repeat read", {16'd0, d}, {16'd0, exp_rd(1'b0, 11'h033, 2'b11)});
    host_rd(2'b01, d);
    chk("R7 byte repeat", {16'd0, d}, {16'd0, exp_rd(1'b0, 11'h033, 2'b01)});

    // R1: area bit and flush on reload
    base = acc_cnt;
    load_ptr(1'b1, 1'b1, 1'b1, 11'h010);
    cycles(3);
    chk("R1 area address", {20'd0, acc_addr[4'(base)]}, 32'h810);
    host_rd(2'b11, d);
    chk("R1 area data", {16'd0, d}, {16'd0, exp_rd(1'b1, 11'h010, 2'b11)});
    load_ptr(1'b0, 1'b1, 1'b1, 11'h200);
    cycles(3);
    load_ptr(1'b0, 1'b1, 1'b1, 11'h301);
    host_rd(2'b11, d);
    chk("R1 reload flush", {16'd0, d}, {16'd0, exp_rd(1'b0, 11'h301, 2'b11)});

    // R9: write threshold while host keeps writing
    load_ptr(1'b0, 1'b1, 1'b0, 11'h040);
    base = acc_cnt;
    @(negedge clk);
    dat_wr = 1'b1; dat_be = 2'b11; dat_wdata = 16'hA1A0;
    @(posedge clk); #1;
    dat_wdata = 16'hB1B0;
    @(posedge clk); #1;
    chk("R9 no write at two bytes", 32'(acc_cnt - base), 32'd0);
    dat_wdata = 16'hC1C0;
    @(negedge clk); #1;
    chk("R6 write queue full", {31'd0, not_ready}, 32'd1);
    @(posedge clk); #1;
    chk("R9 write at four bytes", 32'(acc_cnt - base), 32'd1);
    @(negedge clk); #1;
    while (not_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    dat_wr = 1'b0;
    cycles(6);
    for (int j = 0; j < 6; j++) expm[12'h040 + 12'(j)] = 8'({8'hA0, 8'hA1, 8'hB0, 8'hB1, 8'hC0, 8'hC1} >> (8 * (5 - j)));
    for (int j = 0; j < 6; j++) chk("R8 burst bytes", {24'd0, mem[12'h040 + 12'(j)]}, {24'd0, expm[12'h040 + 12'(j)]});

    // R10: non-incrementing writes all hit the pointer
    load_ptr(1'b0, 1'b0, 1'b0, 11'h061);
    host_wr(2'b01, 16'h00AA);
    host_wr(2'b10, 16'hBB00);
    cycles(4);
    expm[12'h061] = 8'hBB;
    chk("R10 byte overwrite", {24'd0, mem[12'h061]}, 32'hBB);
    host_wr(2'b11, 16'hD1C2);
    cycles(4);
    expm[12'h061] = 8'hC2; expm[12'h062] = 8'hD1;
    chk("R10 word low", {24'd0, mem[12'h061]}, 32'hC2);
    chk("R10 word high", {24'd0, mem[12'h062]}, 32'hD1);

    // R11: pointer load held while writes pending
    force_gnt = 1'b0;
    cycles(2);
    load_ptr(1'b0, 1'b1, 1'b0, 11'h070);
    host_wr(2'b11, 16'h5A6B);
    @(negedge clk);
    ptr_we = 1'b1; ptr_wdata = {3'b011, 2'b00, 11'h070};
    #1;
    chk("R11 pointer held", {31'd0, not_ready}, 32'd1);
    force_gnt = 1'b1;
    while (not_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ptr_we = 1'b0;
    expm[12'h070] = 8'h6B; expm[12'h071] = 8'h5A;
    chk("R11 drained low", {24'd0, mem[12'h070]}, 32'h6B);
    chk("R11 drained high", {24'd0, mem[12'h071]}, 32'h5A);

    // random writes (R8) and reads (R4, R5) under a random grant
    rand_gnt = 1'b1;
    for (int k = 0; k < 10; k++) begin
      rcv = 1'($urandom);
      off = 11'($urandom);
      load_ptr(rcv, 1'b1, 1'b0, off);
      wn = 0;
      for (int a = 0; a < 6; a++) begin
        be = 2'($urandom % 3 + 1);
        d = 16'($urandom);
        host_wr(be, d);
        if (be == 2'b11) begin
          expm[ix(rcv, off)] = d[7:0]; wl[wn] = ix(rcv, off); wn++; off = off + 11'd1;
          expm[ix(rcv, off)] = d[15:8]; wl[wn] = ix(rcv, off); wn++; off = off + 11'd1;
        end else begin
          expm[ix(rcv, off)] = (be == 2'b01) ? d[7:0] : d[15:8];
          wl[wn] = ix(rcv, off); wn++; off = off + 11'd1;
        end
      end
      load_ptr(rcv, 1'b1, 1'b1, off);
      cycles(2);
      for (int j = 0; j < wn; j++) chk("R8 random write", {24'd0, mem[wl[j]]}, {24'd0, expm[wl[j]]});
    end
    for (int k = 0; k < 20; k++) begin
      rcv = 1'($urandom);
      off = 11'($urandom);
      load_ptr(rcv, 1'b1, 1'b1, off);
      for (int a = 0; a < 10; a++) begin
        be = 2'($urandom % 3 + 1);
        host_rd(be, d);
        chk((be == 2'b11) ? "R4 stream word" : "R5 stream byte", {16'd0, d}, {16'd0, exp_rd(rcv, off, be)});
        off = off + ((be == 2'b11) ? 11'd2 : 11'd1);
      end
    end
    chk("R12 no odd word cycles", 32'(odd_word), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule